// File: doc/BRIEF.md
# Pipelined SPI Register Slave

This block lets an external host reach a small byte-addressed register file over a four-wire serial link. The serial clock idles high. The slave captures MOSI on the rising edge and launches MISO on the falling edge, most significant bit first. A transfer is a 16-bit frame framed by an active-low chip select. Each frame carries one command. A read command names a register, and that register's 16-bit word comes back on MISO during the next frame. The host can therefore issue back-to-back reads in full duplex, with each frame collecting the result of the read before it.

All serial inputs are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. A frame counts only if chip select rises after exactly 16 rising clock edges. Any other count throws the frame away and records a sticky link-error bit in a status word. The register set holds two sampled words, two read/write scratch words and the status word. A sampled word carries a new-data flag and an error flag beside its 14-bit sample. Reading the word clears its new-data flag, and every sample strobe sets the flag again.

Top module: `spireg_slave`

## Requirements
- R1: MOSI is captured on rising serial-clock edges and MISO changes only after falling edges, both most significant bit first; a frame is the span while chip select is low.
- R2: Command bit 15 selects a write (1) or a read (0), bits 13:8 give the 6-bit byte address, bits 7:0 give the write byte; bit 14 is ignored, and bits 7:0 are ignored on reads.
- R3: The word chosen by a read command is shifted out on MISO during the following frame, and read address bit 0 is ignored (either byte address of a word selects it).
- R4: A write updates one byte of a scratch word at byte addresses 0x20 to 0x23 (even address = bits 7:0, odd address = bits 15:8) and leaves the other byte unchanged; the frame after a write returns 0x0000.
- R5: If chip select rises after any number of rising edges other than 16, no write happens, the pending response word is kept for the next frame, and status bit 0 is set.
- R6: Sampled words at byte addresses 0x00 and 0x02 return bit 15 = new-data flag, bit 14 = error flag (1 while the status word is non-zero), and bits 13:0 = the latest sample.
- R7: A sample strobe loads every sampled word and sets its new-data flag, and a read of that word clears the flag. When both happen in the same cycle, the flag stays set.
- R8: A read of the status word at 0x3C returns {15'b0, link error} and clears the error bit after the word is captured.
- R9: After reset, MISO is low and the first frame returns 0x0000; MISO is low whenever chip select is high.
- R10: Writes to sampled, status or unmapped addresses change nothing, and reads of unmapped addresses return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idles high |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial command data from the host |
| spi_miso | output | 1 | Serial response data to the host |
| smp_stb | input | 1 | One-cycle strobe that loads new samples |
| smp_data | input | 28 | Samples, word 0 in bits 13:0 and word 1 in bits 27:14 |

## Verification
The embedded properties check the per-cycle rules on every cycle. These cover the bit counter stepping on each captured edge, MISO held low outside a frame, a new-data flag set after every strobe and cleared after a read of its word, the link-error bit latching after a malformed frame and clearing after a status read, scratch words staying unchanged unless a write frame completes, and a write frame preparing a zero response. Other behaviour needs the bench's frame sequences to show it. That includes the one-frame delay of read data, byte placement within a word, the response surviving an aborted frame, the error flag appearing inside a sampled word, and short and long frames both being rejected.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int ADDR_W     = 6;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 2 * BYTE_W;
  localparam int FRAME_BITS = 2 + ADDR_W + BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 1;

  typedef struct packed {
    logic              wr;
    logic              spare;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int               WIDTH = 3,
  parameter logic [WIDTH-1:0] IDLE  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [1:0] stg_q, stg_d;
    assign stg_d = {stg_q[0], din[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {2{IDLE[g]}};
      else        stg_q <= stg_d;
    end
    assign dout[g] = stg_q[1];
  end
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
  import spireg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_rise,
  input  logic                  sclk_fall,
  input  logic                  cs_idle,
  input  logic                  cs_start,
  input  logic                  cs_end,
  input  logic                  mosi_bit,
  input  logic [FRAME_BITS-1:0] resp_word,
  output logic                  miso,
  output logic                  frame_ok,
  output logic                  frame_bad,
  output cmd_t                  cmd
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] rx_q, rx_d, tx_q, tx_d;
  logic                  miso_q, miso_d;

  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    miso_d = miso_q;
    if (cs_idle) begin
      cnt_d  = '0;
      rx_d   = '0;
      tx_d   = '0;
      miso_d = 1'b0;
    end else begin
      if (cs_start) tx_d = resp_word;
      if (sclk_rise) begin
        rx_d = {rx_q[FRAME_BITS-2:0], mosi_bit};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      end
      if (sclk_fall) begin
        miso_d = tx_q[FRAME_BITS-1];
        tx_d   = {tx_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      miso_q <= miso_d;
    end
  end

  assign frame_ok  = cs_end && (cnt_q == CNT_FULL);
  assign frame_bad = cs_end && (cnt_q != CNT_FULL);
  assign cmd       = cmd_t'(rx_q);
  assign miso      = miso_q;

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !miso_q);
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_idle && cnt_q < CNT_FULL) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R1
  miso_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !cs_idle) |=> miso_q == $past(tx_q[FRAME_BITS-1]));
endmodule

// File: rtl/spireg_regs.sv
module spireg_regs
  import spireg_pkg::*;
#(
  parameter int NUM_SMP   = 2,
  parameter int SMP_W     = 14,
  parameter int NUM_RW    = 2,
  parameter int RW_BASE   = 16,
  parameter int STAT_WORD = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_ok,
  input  logic                     frame_bad,
  input  cmd_t                     cmd,
  input  logic                     smp_stb,
  input  logic [NUM_SMP*SMP_W-1:0] smp_data,
  output logic [WORD_W-1:0]        resp_word
);
  localparam int IDX_W = ADDR_W - 1;

  logic [SMP_W-1:0]  smp_q [NUM_SMP];
  logic [SMP_W-1:0]  smp_d [NUM_SMP];
  logic [NUM_SMP-1:0] nd_q, nd_d;
  logic [WORD_W-1:0] rw_q [NUM_RW];
  logic [WORD_W-1:0] rw_d [NUM_RW];
  logic              err_q, err_d;
  logic [WORD_W-1:0] hold_q, hold_d;

  logic [IDX_W-1:0]  word_idx;
  logic              hi_sel, rd_req, wr_req, ea_flag;
  logic [WORD_W-1:0] status_word, rd_word;
  logic              unused_spare;

  assign word_idx     = cmd.addr[ADDR_W-1:1];
  assign hi_sel       = cmd.addr[0];
  assign rd_req       = frame_ok && !cmd.wr;
  assign wr_req       = frame_ok && cmd.wr;
  assign status_word  = {{(WORD_W-1){1'b0}}, err_q};
  assign ea_flag      = |status_word;
  assign unused_spare = cmd.spare;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_SMP; i++) begin
      if (word_idx == IDX_W'(i)) begin
        rd_word[WORD_W-1]  = nd_q[i];
        rd_word[WORD_W-2]  = ea_flag;
        rd_word[SMP_W-1:0] = smp_q[i];
      end
    end
    for (int j = 0; j < NUM_RW; j++) begin
      if (word_idx == IDX_W'(RW_BASE + j)) rd_word = rw_q[j];
    end
    if (word_idx == IDX_W'(STAT_WORD)) rd_word = status_word;
  end

  always_comb begin
    smp_d  = smp_q;
    nd_d   = nd_q;
    rw_d   = rw_q;
    err_d  = err_q;
    hold_d = hold_q;
    for (int i = 0; i < NUM_SMP; i++) begin
      if (rd_req && word_idx == IDX_W'(i)) nd_d[i] = 1'b0;
      if (smp_stb) begin
        smp_d[i] = smp_data[i*SMP_W +: SMP_W];
        nd_d[i]  = 1'b1;
      end
    end
    for (int j = 0; j < NUM_RW; j++) begin
      if (wr_req && word_idx == IDX_W'(RW_BASE + j)) begin
        if (hi_sel) rw_d[j][WORD_W-1:BYTE_W] = cmd.data;
        else        rw_d[j][BYTE_W-1:0]      = cmd.data;
      end
    end
    if (rd_req && word_idx == IDX_W'(STAT_WORD)) err_d = 1'b0;
    if (frame_bad) err_d = 1'b1;
    if (frame_ok) hold_d = rd_req ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SMP; i++) smp_q[i] <= '0;
      for (int j = 0; j < NUM_RW; j++)  rw_q[j]  <= '0;
      nd_q   <= '0;
      err_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      smp_q  <= smp_d;
      rw_q   <= rw_d;
      nd_q   <= nd_d;
      err_q  <= err_d;
      hold_q <= hold_d;
    end
  end

  assign resp_word = hold_q;

  // R7
  nd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> &nd_q);
  // R7
  nd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && word_idx == '0 && !smp_stb) |=> !nd_q[0]);
  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> err_q);
  // R8
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && word_idx == IDX_W'(STAT_WORD)) |=> (!err_q && resp_word[0] == $past(err_q)));
  // R4
  wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> resp_word == '0);
  // R10
  rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> ($stable(rw_q[0]) && $stable(rw_q[NUM_RW-1])));
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int NUM_SMP   = 2,
  parameter int SMP_W     = 14,
  parameter int NUM_RW    = 2,
  parameter int RW_BASE   = 16,
  parameter int STAT_WORD = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spi_sclk,
  input  logic                     spi_cs_n,
  input  logic                     spi_mosi,
  output logic                     spi_miso,
  input  logic                     smp_stb,
  input  logic [NUM_SMP*SMP_W-1:0] smp_data
);
  logic [1:0] rst_q, rst_d;
  logic       rst_i_n;
  assign rst_d = {rst_q[0], 1'b1};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_d;
  end
  assign rst_i_n = rst_q[1];

  logic [2:0] pin_s;
  spireg_sync #(.WIDTH(3), .IDLE(3'b110)) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .din  ({spi_cs_n, spi_sclk, spi_mosi}),
    .dout (pin_s)
  );

  logic [1:0] edge_q, edge_d;
  assign edge_d = pin_s[2:1];
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) edge_q <= 2'b11;
    else          edge_q <= edge_d;
  end

  logic sclk_rise, sclk_fall, cs_start, cs_end;
  assign sclk_rise = pin_s[1] && !edge_q[0];
  assign sclk_fall = !pin_s[1] && edge_q[0];
  assign cs_start  = !pin_s[2] && edge_q[1];
  assign cs_end    = pin_s[2] && !edge_q[1];

  logic              frame_ok, frame_bad;
  cmd_t              cmd;
  logic [WORD_W-1:0] resp_word;

  spireg_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .cs_idle  (pin_s[2]),
    .cs_start (cs_start),
    .cs_end   (cs_end),
    .mosi_bit (pin_s[0]),
    .resp_word(resp_word),
    .miso     (spi_miso),
    .frame_ok (frame_ok),
    .frame_bad(frame_bad),
    .cmd      (cmd)
  );

  spireg_regs #(
    .NUM_SMP  (NUM_SMP),
    .SMP_W    (SMP_W),
    .NUM_RW   (NUM_RW),
    .RW_BASE  (RW_BASE),
    .STAT_WORD(STAT_WORD)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .frame_ok (frame_ok),
    .frame_bad(frame_bad),
    .cmd      (cmd),
    .smp_stb  (smp_stb),
    .smp_data (smp_data),
    .resp_word(resp_word)
  );
endmodule

// File: tb/spireg_slave_bench.sv
module spireg_slave_bench;
  localparam int HALF = 8;
  localparam int NV   = 13;

  logic        clk = 1'b0;
  logic        rst_n, sclk, cs_n, mosi, stb;
  logic        miso;
  logic [27:0] sdat;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  spireg_slave u_spireg_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .smp_stb(stb), .smp_data(sdat)
  );

  // {requirement number, command, expected response on MISO in this frame}
  localparam logic [35:0] VEC [NV] = '{
    {4'd9,  16'h0000, 16'h0000},  // R9 first frame after reset
    {4'd6,  16'h0200, 16'h9234},  // R6 R3 word 0 with new data
    {4'd6,  16'h0000, 16'hAABC},  // R6 word 1 with new data
    {4'd7,  16'hA0A5, 16'h1234},  // R7 flag cleared by earlier read
    {4'd2,  16'hE15A, 16'h0000},  // R2 bit 14 set, R4 write response
    {4'd4,  16'h2000, 16'h0000},  // R4 write response
    {4'd4,  16'h2300, 16'h5AA5},  // R4 both bytes placed
    {4'd3,  16'h8077, 16'h0000},  // R3 odd read address selects word 0x22
    {4'd4,  16'h0000, 16'h0000},  // R4 write response
    {4'd10, 16'h1800, 16'h1234},  // R10 sample untouched by write
    {4'd10, 16'h0000, 16'h0000},  // R10 unmapped read
    {4'd2,  16'h3CFF, 16'h1234},  // R2 data bits ignored on read
    {4'd8,  16'h0000, 16'h0000}   // R8 status clear
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nclk, output logic [15:0] r);
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b0;
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 16) r[15-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic strobe(input logic [13:0] s1, input logic [13:0] s0);
    @(negedge clk);
    sdat = {s1, s0};
    stb  = 1'b1;
    @(negedge clk);
    stb  = 1'b0;
  endtask

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; mosi = 1'b0; stb = 1'b0; sdat = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 reset miso", {15'b0, miso}, 16'h0000);
    strobe(14'h2ABC, 14'h1234);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][31:16], 16, r);
      check($sformatf("R%0d R1 vector %0d", VEC[i][35:32], i), r, VEC[i][15:0]);
    end
    check("R9 miso idle between frames", {15'b0, miso}, 16'h0000);

    // R5 short frame: write of 0x21 must not land
    xfer(16'hA1FF, 15, r);
    xfer(16'h2000, 16, r);
    check("R5 response kept after short frame", r, 16'h1234);
    xfer(16'h3C00, 16, r);
    check("R5 no write from short frame", r, 16'h5AA5);
    xfer(16'h0000, 16, r);
    check("R8 status shows link error", r, 16'h0001);
    xfer(16'h3C00, 16, r);
    check("R8 error cleared by status read", r, 16'h1234);
    // R5 long frame
    xfer(16'h0000, 17, r);
    xfer(16'h0000, 16, r);
    check("R5 response kept after long frame", r, 16'h0000);
    xfer(16'h3C00, 16, r);
    check("R6 error flag in sampled word", r, 16'h5234);
    xfer(16'h0000, 16, r);
    check("R5 long frame sets error", r, 16'h0001);
    // R7 new samples
    strobe(14'h3FFF, 14'h0111);
    xfer(16'h0000, 16, r);
    check("R7 snapshot before strobe", r, 16'h1234);
    xfer(16'h0200, 16, r);
    check("R7 flag set by strobe", r, 16'h8111);
    xfer(16'h0000, 16, r);
    check("R6 word 1 new sample", r, 16'hBFFF);
    xfer(16'h0000, 16, r);
    check("R7 flag cleared by read", r, 16'h0111);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule